// File: doc/BRIEF.md
# Keyed Data-EEPROM Write Controller

This block sits between a CPU register bus and a byte-wide data EEPROM. Software reaches four byte-wide registers through it: an address register, a data register, a control register and a key register. The key register has no storage behind it. A write to the array starts only when three conditions hold. The write-enable bit is already set. The two key bytes have just been written to the key register. The control write that sets the write-start bit follows the second key byte directly. The write-start bit then reads as 1 while a modelled array busy period runs, and it clears itself when the byte is committed. Completion also raises a sticky done flag, which drives an interrupt pin.

Register accesses use a valid/ready request channel and a valid/ready response channel. A request is taken on a clock edge where `bus_valid` and `bus_ready` are both high. Every accepted read produces exactly one response, which becomes valid on the following edge. A response holds its data until `rsp_ready` is seen high. While a response is waiting, `bus_ready` is low, so reads and writes alike are held back. `bus_ready` is also low while the synchronous warm reset is asserted. The array keeps its contents through both resets. The power-on reset is asynchronous and clears every register, including the error flag. The warm reset is synchronous, and it records a write that it cuts short.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: Register select codes on `bus_sel` are 0 = address, 1 = data, 2 = control, 3 = key. After power-on reset, address, data and control all read 0, and `wip`, `done_irq` and `wr_err` are low.
- R2: The key register stores nothing and always reads 0x00.
- R3: A write starts only if it is requested by a control write with bit 1 (write-start) set. The two accepted accesses just before that control write must be writes to the key register of 0x55 and then 0xAA. Any other accepted access, including a read or a repeated 0x55, sends the key sequence back to idle.
- R4: A write is refused unless the stored control bit 2 (write-enable) was already 1 before the control write that requests it.
- R5: Once a write starts, control bit 1 and `wip` are 1 for exactly WR_LAT cycles. On the edge where they clear, the latched data byte is stored at the latched address.
- R6: While a write is in progress, changes to the address or data register do not affect the byte being written, and a further write request is refused.
- R7: Control bit 4 (done) and `done_irq` are set on the edge where a write completes. A control write with bit 4 at 0 clears them.
- R8: A control write with bit 0 (read strobe) set loads the data register from the array byte at the current address when no write is in progress. Bit 0 always reads 0.
- R9: A read or write strobe reaches the array only if control bits 7:6 in that same control write are both 0. Otherwise a read leaves the data register unchanged, and a write is refused.
- R10: A control write with bit 5 set increments the address register modulo 2^ADDR_W, so 0xFF becomes 0x00. Bit 5 always reads 0.
- R11: If the warm reset is asserted during a write, control bit 3 (error) and `wr_err` are set, the array byte is not written and `wip` clears. Without a write in progress, the warm reset leaves the error flag unchanged. Power-on reset clears the error flag.
- R12: A read response becomes valid on the edge after the request is accepted. While `rsp_ready` is low, the response keeps `rsp_valid` high and its data stable, and `bus_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous warm reset, active high |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted when high |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken when high |
| rsp_data | output | 8 | Read response data |
| wip | output | 1 | Write in progress |
| done_irq | output | 1 | Write-complete interrupt flag |
| wr_err | output | 1 | Aborted-write error flag |

## Verification
On every cycle, the assertions check the following. A write can begin only after the second key byte and only with write-enable stored. Any accepted access leaves the armed state. A completed write raises the done flag. A warm reset that cuts a write short sets the error flag. A held response stays stable, and key reads return zero. Other behaviour can be shown only by the bench scenarios, because each needs a whole sequence of register accesses and a reference model of the array: the exact busy length, the byte committed while the address and data registers change during busy, the refusal of broken or reordered key sequences and of non-data selects, read-back after the read strobe, address wrap-around, and array contents surviving an aborted write.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int B_RDGO = 0;
  localparam int B_WRGO = 1;
  localparam int B_WEN  = 2;
  localparam int B_ERR  = 3;
  localparam int B_DONE = 4;
  localparam int B_INC  = 5;
  localparam int B_CFG  = 6;
  localparam int B_SPC  = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_HALF  = 2'd1,
    K_ARMED = 2'd2
  } key_st_e;
endpackage

// File: rtl/eectl_unlock.sv
module eectl_unlock
  import eectl_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst,
  input  logic       acc,
  input  logic       we,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic       armed
);
  key_st_e st_q;
  logic    hit_first, hit_second;

  assign hit_first  = we && (sel == SEL_KEY) && (wdata == KEY_FIRST);
  assign hit_second = we && (sel == SEL_KEY) && (wdata == KEY_SECOND);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q <= K_IDLE;
    end else if (sys_rst) begin
      st_q <= K_IDLE;
    end else if (acc) begin
      unique case (st_q)
        K_IDLE:  st_q <= hit_first  ? K_HALF  : K_IDLE;
        K_HALF:  st_q <= hit_second ? K_ARMED : K_IDLE;
        default: st_q <= K_IDLE;
      endcase
    end
  end

  assign armed = (st_q == K_ARMED);

  // R3: arming only ever follows an accepted second key byte
  assert_arm_after_key_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(armed) |-> $past(acc && hit_second));

  // R3: any accepted access consumes the armed state
  assert_access_disarms_R3: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    armed && acc |=> !armed);
endmodule

// File: rtl/eectl_timer.sv
module eectl_timer #(
  parameter int WR_LAT = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(WR_LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (abort) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(WR_LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = (cnt_q != '0);
  assign finish = (cnt_q == CW'(1)) && !abort;

  // R5: an accepted start is visible as busy on the next cycle
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!por_n)
    start && !abort |=> busy);
endmodule

// File: rtl/eectl_array.sv
module eectl_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  // nonvolatile model: no reset on the storage
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eectl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WR_LAT = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst,
  input  logic       bus_valid,
  output logic       bus_ready,
  input  logic       bus_we,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       wip,
  output logic       done_irq,
  output logic       wr_err
);
  logic [ADDR_W-1:0] addr_q, w_addr_q;
  logic [7:0]        data_q, w_data_q, arr_rdata, rb_data, rsp_data_q;
  logic              wen_q, spc_q, cfg_q, done_q, err_q, rsp_valid_q;
  logic              acc, ctrl_wr, space_ok, start, rd_go, inc_go;
  logic              armed, busy, finish;

  assign bus_ready = (!rsp_valid_q || rsp_ready) && !sys_rst;
  assign acc       = bus_valid && bus_ready;
  assign ctrl_wr   = acc && bus_we && (bus_sel == SEL_CTRL);
  assign space_ok  = !bus_wdata[B_SPC] && !bus_wdata[B_CFG];
  assign start     = ctrl_wr && bus_wdata[B_WRGO] && armed && wen_q && space_ok && !busy;
  assign rd_go     = ctrl_wr && bus_wdata[B_RDGO] && space_ok && !busy;
  assign inc_go    = ctrl_wr && bus_wdata[B_INC];

  eectl_unlock u_unlock (
    .clk     (clk),
    .por_n   (por_n),
    .sys_rst (sys_rst),
    .acc     (acc),
    .we      (bus_we),
    .sel     (bus_sel),
    .wdata   (bus_wdata),
    .armed   (armed)
  );

  eectl_timer #(.WR_LAT(WR_LAT)) u_timer (
    .clk    (clk),
    .por_n  (por_n),
    .abort  (sys_rst),
    .start  (start),
    .busy   (busy),
    .finish (finish)
  );

  eectl_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (finish),
    .waddr (w_addr_q),
    .wdata (w_data_q),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  // address and data registers
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (sys_rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (acc && bus_we && (bus_sel == SEL_ADDR)) addr_q <= bus_wdata[ADDR_W-1:0];
      else if (inc_go)                            addr_q <= addr_q + 1'b1;
      if (acc && bus_we && (bus_sel == SEL_DATA)) data_q <= bus_wdata;
      else if (rd_go)                             data_q <= arr_rdata;
    end
  end

  // latched write target
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      w_addr_q <= '0;
      w_data_q <= '0;
    end else if (start) begin
      w_addr_q <= addr_q;
      w_data_q <= data_q;
    end
  end

  // control bits
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wen_q  <= 1'b0;
      spc_q  <= 1'b0;
      cfg_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (sys_rst) begin
      wen_q  <= 1'b0;
      spc_q  <= 1'b0;
      cfg_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= err_q | busy;
    end else begin
      if (ctrl_wr) begin
        wen_q <= bus_wdata[B_WEN];
        spc_q <= bus_wdata[B_SPC];
        cfg_q <= bus_wdata[B_CFG];
        err_q <= bus_wdata[B_ERR];
      end
      if (finish)       done_q <= 1'b1;
      else if (ctrl_wr) done_q <= bus_wdata[B_DONE];
    end
  end

  // register read-back
  always_comb begin
    unique case (reg_sel_e'(bus_sel))
      SEL_ADDR: rb_data = 8'(addr_q);
      SEL_DATA: rb_data = data_q;
      SEL_CTRL: rb_data = {spc_q, cfg_q, 1'b0, done_q, err_q, wen_q, busy, 1'b0};
      default:  rb_data = 8'h00;
    endcase
  end

  // response channel
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (sys_rst) begin
      rsp_valid_q <= 1'b0;
    end else if (acc && !bus_we) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rb_data;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign wip       = busy;
  assign done_irq  = done_q;
  assign wr_err    = err_q;

  // R4: a write never begins unless write-enable was already stored
  assert_wen_before_start_R4: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    $rose(busy) |-> $past(wen_q));

  // R3: a write never begins unless the key pair was just seen
  assert_key_before_start_R3: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    $rose(busy) |-> $past(armed));

  // R7: normal completion raises the done flag
  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    $fell(busy) && !$past(sys_rst) |-> done_q);

  // R11: warm reset during a write leaves the error flag set
  assert_err_on_abort_R11: assert property (@(posedge clk) disable iff (!por_n)
    $past(sys_rst) && $past(busy) |-> err_q);

  // R12: a response held back keeps valid and data stable
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R2: key register reads return zero
  assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    acc && !bus_we && (bus_sel == SEL_KEY) |=> rsp_data == 8'h00);
endmodule

// File: tb/eeprom_wr_ctrl_tb_top.sv
module eeprom_wr_ctrl_tb_top;
  localparam int LAT = 12;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_rst = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic       rsp_ready = 1'b1;
  logic       bus_ready, rsp_valid, wip, done_irq, wr_err;
  logic [7:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 1'b0;

  logic [7:0] model [256];
  bit         known [256];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_wr_ctrl #(.ADDR_W(8), .WR_LAT(LAT)) dut_i (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wip(wip), .done_irq(done_irq), .wr_err(wr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp_v);
    check(act == exp_v, req, act, exp_v);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // expected start decision, straight from R3, R4 and R9
  function automatic bit exp_start(input bit wen, input logic [1:0] space, input bit key_ok);
    return wen && (space == 2'b00) && key_ok;
  endfunction

  task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_sel = sel;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic unlock();
    bus_wr(2'd3, 8'h55);
    bus_wr(2'd3, 8'hAA);
  endtask

  task automatic wait_idle();
    while (wip) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    bus_wr(2'd0, a);
    bus_wr(2'd1, d);
    bus_wr(2'd2, 8'h04);
    unlock();
    bus_wr(2'd2, 8'h06);
    wait_idle();
    model[a] = d; known[a] = 1'b1;
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
    bus_wr(2'd0, a);
    bus_wr(2'd2, 8'h01);
    bus_rd(2'd1, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] r;
    int t0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 wip", int'(wip), 0);
    check_eq("R1 done_irq", int'(done_irq), 0);
    check_eq("R1 wr_err", int'(wr_err), 0);
    bus_rd(2'd2, r); check_eq("R1 ctrl", int'(r), 0);
    bus_rd(2'd0, r); check_eq("R1 addr", int'(r), 0);
    bus_rd(2'd1, r); check_eq("R1 data", int'(r), 0);

    // R2 key register stores nothing
    bus_wr(2'd3, 8'h77);
    bus_rd(2'd3, r); check_eq("R2 key read", int'(r), 0);

    // R5 busy length and commit, R7 done
    bus_wr(2'd0, 8'h10); bus_wr(2'd1, 8'h3C); bus_wr(2'd2, 8'h04);
    unlock();
    bus_wr(2'd2, 8'h06);
    t0 = cyc;
    check_eq("R5 wip after start", int'(wip), 1);
    bus_rd(2'd2, r); check_eq("R5 ctrl busy bit", int'(r[1]), 1);
    wait_idle();
    check_eq("R5 busy cycles", cyc - t0, LAT);
    model[8'h10] = 8'h3C; known[8'h10] = 1'b1;
    check_eq("R7 done_irq", int'(done_irq), 1);
    bus_rd(2'd2, r); check_eq("R7 ctrl done bit", int'(r[4]), 1);
    rd_byte(8'h10, r); check_eq("R8 read back", int'(r), 8'h3C);
    bus_rd(2'd2, r); check_eq("R8 strobe reads 0", int'(r[0]), 0);
    bus_wr(2'd2, 8'h04);
    @(negedge clk);
    check_eq("R7 done clear", int'(done_irq), 0);

    // R4 write-enable not stored beforehand
    bus_wr(2'd1, 8'h99); bus_wr(2'd2, 8'h00);
    unlock();
    bus_wr(2'd2, 8'h06);
    check_eq("R4 refused wip", int'(wip), 0);
    rd_byte(8'h10, r); check_eq("R4 array unchanged", int'(r), 8'h3C);

    // R3 broken sequences
    bus_wr(2'd1, 8'h99); bus_wr(2'd2, 8'h04);
    bus_wr(2'd3, 8'h55); bus_rd(2'd0, r); bus_wr(2'd3, 8'hAA); bus_wr(2'd2, 8'h06);
    check_eq("R3 read between keys", int'(wip), 0);
    bus_wr(2'd3, 8'hAA); bus_wr(2'd3, 8'h55); bus_wr(2'd2, 8'h06);
    check_eq("R3 reversed keys", int'(wip), 0);
    bus_wr(2'd3, 8'h55); bus_wr(2'd3, 8'h55); bus_wr(2'd3, 8'hAA); bus_wr(2'd2, 8'h06);
    check_eq("R3 repeated first key", int'(wip), 0);
    unlock(); bus_wr(2'd0, 8'h10); bus_wr(2'd2, 8'h06);
    check_eq("R3 access after pair", int'(wip), 0);
    rd_byte(8'h10, r); check_eq("R3 array unchanged", int'(r), 8'h3C);

    // R9 non-data selects
    bus_wr(2'd2, 8'h04); unlock(); bus_wr(2'd2, 8'h86);
    check_eq("R9 write refused", int'(wip), 0);
    bus_wr(2'd1, 8'h5A); bus_wr(2'd2, 8'h41);
    bus_rd(2'd1, r); check_eq("R9 read blocked", int'(r), 8'h5A);

    // R6 target latched, restart refused while busy
    do_write(8'h21, 8'h44);
    bus_wr(2'd0, 8'h20); bus_wr(2'd1, 8'h11); bus_wr(2'd2, 8'h04);
    unlock();
    bus_wr(2'd2, 8'h06);
    t0 = cyc;
    bus_wr(2'd0, 8'h21); bus_wr(2'd1, 8'hEE);
    unlock(); bus_wr(2'd2, 8'h06);
    wait_idle();
    check_eq("R6 no restart", cyc - t0, LAT);
    model[8'h20] = 8'h11; known[8'h20] = 1'b1;
    rd_byte(8'h20, r); check_eq("R6 latched byte", int'(r), 8'h11);
    rd_byte(8'h21, r); check_eq("R6 neighbour intact", int'(r), 8'h44);

    // R10 increment and wrap
    bus_wr(2'd0, 8'hFF); bus_wr(2'd2, 8'h20);
    bus_rd(2'd0, r); check_eq("R10 wrap", int'(r), 0);
    bus_wr(2'd0, 8'h7E); bus_wr(2'd2, 8'h20);
    bus_rd(2'd0, r); check_eq("R10 increment", int'(r), 8'h7F);
    bus_rd(2'd2, r); check_eq("R10 bit reads 0", int'(r[5]), 0);

    // R11 warm reset
    @(negedge clk); sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    check_eq("R11 idle reset no error", int'(wr_err), 0);
    do_write(8'h30, 8'h12);
    bus_wr(2'd0, 8'h30); bus_wr(2'd1, 8'hC3); bus_wr(2'd2, 8'h04);
    unlock(); bus_wr(2'd2, 8'h06);
    repeat (3) @(negedge clk);
    sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    check_eq("R11 wr_err", int'(wr_err), 1);
    check_eq("R11 wip cleared", int'(wip), 0);
    bus_rd(2'd2, r); check_eq("R11 ctrl after abort", int'(r), 8'h08);
    rd_byte(8'h30, r); check_eq("R11 array untouched", int'(r), 8'h12);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    check_eq("R11 por clears error", int'(wr_err), 0);

    // R12 response back-pressure
    rsp_ready = 1'b0;
    bus_wr(2'd0, 8'h6B);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_sel = 2'd0;
    @(negedge clk);
    bus_valid = 1'b0;
    check_eq("R12 rsp_valid", int'(rsp_valid), 1);
    check_eq("R12 data", int'(rsp_data), 8'h6B);
    repeat (3) @(negedge clk);
    check_eq("R12 held valid", int'(rsp_valid), 1);
    check_eq("R12 held data", int'(rsp_data), 8'h6B);
    check_eq("R12 ready low", int'(bus_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check_eq("R12 released", int'(rsp_valid), 0);

    // random attempts against the model
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a, d;
      logic [1:0] space;
      bit wen, key_ok, e;
      a = 8'($urandom_range(0, 255));
      d = 8'($urandom);
      wen = ($urandom_range(0, 3) != 0);
      key_ok = ($urandom_range(0, 3) != 0);
      space = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      e = exp_start(wen, space, key_ok);
      bus_wr(2'd0, a); bus_wr(2'd1, d);
      bus_wr(2'd2, {5'b0, wen, 2'b00});
      bus_wr(2'd3, 8'h55);
      bus_wr(2'd3, key_ok ? 8'hAA : (8'hAA ^ 8'($urandom_range(1, 255))));
      bus_wr(2'd2, {space, 3'b000, wen, 2'b10});
      check_eq("R3 R4 R9 random start", int'(wip), int'(e));
      if (e) begin
        wait_idle();
        model[a] = d; known[a] = 1'b1;
      end
      if (known[a]) begin
        rd_byte(a, r); check_eq("R5 R8 random readback", int'(r), int'(model[a]));
      end
    end

    summary();
  end
endmodule